// File: doc/BRIEF.md
# SIMD Pairwise Maximum/Minimum Unit

This block decodes and executes a three-register vector instruction that forms pairwise maxima or minima. It reads two 64-bit vector registers. Inside each source, every pair of neighbouring elements is reduced to one element. The reductions of the first source fill the low half of the 64-bit result, and those of the second source fill the high half. Elements are 8, 16 or 32 bits wide and are compared as signed or unsigned numbers.

The block holds its own register file. A test port can load and inspect that file. An instruction is presented for one cycle with a valid strobe. In that cycle the block reports whether the word was recognised, whether it is undefined, and, if it writes, the destination index and the result. The write lands in the register file at the closing clock edge. Both sources are read combinationally before that edge, so the result is correct even when the destination is also one of the sources.

Top module: `simd_pairminmax`

## Requirements
- R1: A word is recognised only when bits 31:25 are 1111001, bit 23 is 0, bits 11:8 are 1010 and bit 6 is 0. `match_o` reports this while `valid_i` is high. An unrecognised word raises neither `wr_en_o` nor `undef_o`, and it leaves every register unchanged.
- R2: Bit 24 set selects an unsigned compare, and clear selects a signed compare. Bit 4 set selects minimum, and clear selects maximum.
- R3: Bits 21:20 give the element width: 0 is 8-bit, 1 is 16-bit and 2 is 32-bit. The value 3 raises `undef_o` and suppresses the write.
- R4: Register indices are 5 bits. The destination is {bit 22, bits 15:12}, the first source is {bit 7, bits 19:16} and the second source is {bit 5, bits 3:0}.
- R5: When `regs32_i` is low and bit 4 of any of the three indices is set, `undef_o` is raised and no write happens. When `regs32_i` is high, such indices execute normally.
- R6: Result bits 31:0 come from the first source and bits 63:32 come from the second. Within a half, element i is the max or min of source elements 2i and 2i+1, and element 0 sits in the least significant bits.
- R7: At the 32-bit width, each result half is the max or min of the two 32-bit words of its source.
- R8: Signed compares treat elements as two's complement at the selected width. Unsigned compares treat elements as plain magnitudes.
- R9: The result is correct when the destination index equals either source index.
- R10: The register file has 32 entries of 64 bits, all of which are zero after reset. The test port writes an entry at a clock edge and reads any entry combinationally.
- R11: An executed instruction presents its result in the cycle `valid_i` is high. From the next cycle onward, the destination entry holds that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| regs32_i | input | 1 | High when all 32 vector registers exist |
| tw_en_i | input | 1 | Test-port write enable |
| tw_idx_i | input | 5 | Test-port write index |
| tw_data_i | input | 64 | Test-port write data |
| tr_idx_i | input | 5 | Test-port read index |
| tr_data_o | output | 64 | Test-port read data |
| match_o | output | 1 | Word recognised (qualified by valid) |
| undef_o | output | 1 | Recognised but undefined |
| wr_en_o | output | 1 | Register write performed |
| wr_idx_o | output | 5 | Destination index |
| wr_data_o | output | 64 | Result written |

## Verification
The case that is hardest to reach from the ports is aliasing, where the destination is also a source and the written value must still reflect the pre-instruction contents of both operands. Random index choices rarely produce it, so directed instructions set the destination equal to the first source and then equal to the second. The register is read back through the test port after the edge. Signed/unsigned boundaries are also hard to reach at random, because the outcome depends on values such as 0x80 against 0x7F at every width. Preloaded patterns with such lane values are run under every combination of width, signedness and min/max selection.

// File: rtl/spm_pkg.sv
`timescale 1ns/1ps
package spm_pkg;
   typedef enum logic [1:0] {
      ESZ_8   = 2'd0,
      ESZ_16  = 2'd1,
      ESZ_32  = 2'd2,
      ESZ_BAD = 2'd3
   } esz_e;

   typedef struct packed {
      logic       hit;
      logic       uns;
      logic       is_min;
      esz_e       esz;
      logic [4:0] vd;
      logic [4:0] vn;
      logic [4:0] vm;
   } op_t;
endpackage

// File: rtl/spm_decode.sv
`timescale 1ns/1ps
module spm_decode
   import spm_pkg::*;
(
   input  logic [31:0] insn,
   output op_t         op
);
   always_comb begin
      op.hit    = (insn[31:25] == 7'b1111001) && !insn[23]
                  && (insn[11:8] == 4'b1010) && !insn[6];
      op.uns    = insn[24];
      op.is_min = insn[4];
      op.esz    = esz_e'(insn[21:20]);
      op.vd     = {insn[22], insn[15:12]};
      op.vn     = {insn[7],  insn[19:16]};
      op.vm     = {insn[5],  insn[3:0]};
   end
endmodule

// File: rtl/spm_half_reduce.sv
`timescale 1ns/1ps
module spm_half_reduce
   import spm_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input  logic [2*HALF_W-1:0] src,
   input  esz_e                esz,
   input  logic                uns,
   input  logic                is_min,
   output logic [HALF_W-1:0]   res
);
   localparam int NWID = 3;

   if (HALF_W % 32 != 0 || HALF_W < 32) begin : g_bad_width
      $error("spm_half_reduce: HALF_W must be a positive multiple of 32");
   end

   logic [HALF_W-1:0] by_wid [NWID];

   for (genvar gw = 0; gw < NWID; gw++) begin : g_wid
      localparam int EW   = 8 << gw;
      localparam int NOUT = HALF_W / EW;
      for (genvar gi = 0; gi < NOUT; gi++) begin : g_el
         logic [EW-1:0] a, b;
         logic          a_lt_b, pick_a;
         assign a      = src[(2*gi)*EW +: EW];
         assign b      = src[(2*gi+1)*EW +: EW];
         assign a_lt_b = uns ? (a < b) : ($signed(a) < $signed(b));
         assign pick_a = is_min ? a_lt_b : !a_lt_b;
         assign by_wid[gw][gi*EW +: EW] = pick_a ? a : b;
      end
   end

   always_comb begin
      unique case (esz)
         ESZ_8:   res = by_wid[0];
         ESZ_16:  res = by_wid[1];
         ESZ_32:  res = by_wid[2];
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/spm_regfile.sv
`timescale 1ns/1ps
module spm_regfile #(
   parameter int NREG = 32,
   parameter int DW   = 64,
   localparam int IW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ra_idx,
   output logic [DW-1:0] ra_data,
   input  logic [IW-1:0] rb_idx,
   output logic [DW-1:0] rb_data,
   input  logic [IW-1:0] rc_idx,
   output logic [DW-1:0] rc_data
);
   logic [DW-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign ra_data = mem[ra_idx];
   assign rb_data = mem[rb_idx];
   assign rc_data = mem[rc_idx];
endmodule

// File: rtl/simd_pairminmax.sv
`timescale 1ns/1ps
module simd_pairminmax
   import spm_pkg::*;
#(
   parameter int NREG   = 32,
   parameter int HALF_W = 32,
   localparam int DW    = 2 * HALF_W,
   localparam int RF_IW = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  logic [31:0]   insn_i,
   input  logic          regs32_i,
   input  logic          tw_en_i,
   input  logic [4:0]    tw_idx_i,
   input  logic [DW-1:0] tw_data_i,
   input  logic [4:0]    tr_idx_i,
   output logic [DW-1:0] tr_data_o,
   output logic          match_o,
   output logic          undef_o,
   output logic          wr_en_o,
   output logic [4:0]    wr_idx_o,
   output logic [DW-1:0] wr_data_o
);
   if (NREG != 16 && NREG != 32) begin : g_bad_nreg
      $error("simd_pairminmax: NREG must be 16 or 32");
   end

   op_t           op;
   logic          hi_used, hi_ok, bad;
   logic [DW-1:0] src_n, src_m;
   logic          rf_we;
   logic [4:0]    rf_widx;
   logic [DW-1:0] rf_wdata;

   spm_decode u_dec (.insn(insn_i), .op(op));

   // Upper-bank indices are legal only when the bank exists and is enabled.
   if (NREG == 32) begin : g_full_bank
      assign hi_ok = regs32_i;
   end else begin : g_half_bank
      assign hi_ok = 1'b0;
   end

   assign hi_used   = op.vd[4] | op.vn[4] | op.vm[4];
   assign bad       = (op.esz == ESZ_BAD) | (hi_used & !hi_ok);
   assign match_o   = valid_i & op.hit;
   assign undef_o   = match_o & bad;
   assign wr_en_o   = match_o & !bad;
   assign wr_idx_o  = op.vd;

   spm_half_reduce #(.HALF_W(HALF_W)) u_lo (
      .src(src_n), .esz(op.esz), .uns(op.uns), .is_min(op.is_min),
      .res(wr_data_o[HALF_W-1:0])
   );
   spm_half_reduce #(.HALF_W(HALF_W)) u_hi (
      .src(src_m), .esz(op.esz), .uns(op.uns), .is_min(op.is_min),
      .res(wr_data_o[DW-1:HALF_W])
   );

   // An executed instruction takes the write port over the test port.
   assign rf_we    = wr_en_o | tw_en_i;
   assign rf_widx  = wr_en_o ? op.vd : tw_idx_i;
   assign rf_wdata = wr_en_o ? wr_data_o : tw_data_i;

   spm_regfile #(.NREG(NREG), .DW(DW)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (rf_we),
      .widx   (rf_widx[RF_IW-1:0]),
      .wdata  (rf_wdata),
      .ra_idx (op.vn[RF_IW-1:0]),
      .ra_data(src_n),
      .rb_idx (op.vm[RF_IW-1:0]),
      .rb_data(src_m),
      .rc_idx (tr_idx_i[RF_IW-1:0]),
      .rc_data(tr_data_o)
   );
endmodule

// File: rtl/spm_chk.sv
`timescale 1ns/1ps
module spm_chk #(
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          valid_i,
   input logic [6:0]    prefix,
   input logic [1:0]    size_f,
   input logic          hi_any,
   input logic          regs32_i,
   input logic          match_o,
   input logic          undef_o,
   input logic          wr_en_o,
   input logic [DW-1:0] tr_data_o
);
   a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !match_o |-> (!wr_en_o && !undef_o));

   a_r1_prefix_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && prefix != 7'b1111001) |-> !match_o);

   a_r3_size3_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && size_f == 2'b11) |-> (undef_o && !wr_en_o));

   a_r5_hireg_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !regs32_i && hi_any) |-> (undef_o && !wr_en_o));

   a_r11_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> valid_i);

   a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (tr_data_o == '0));
endmodule

bind simd_pairminmax spm_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .valid_i  (valid_i),
   .prefix   (insn_i[31:25]),
   .size_f   (insn_i[21:20]),
   .hi_any   (insn_i[22] | insn_i[7] | insn_i[5]),
   .regs32_i (regs32_i),
   .match_o  (match_o),
   .undef_o  (undef_o),
   .wr_en_o  (wr_en_o),
   .tr_data_o(tr_data_o)
);

// File: tb/tb_simd_pairminmax.sv
`timescale 1ns/1ps
module tb_simd_pairminmax;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] insn_i = '0;
   logic        regs32_i = 1'b1;
   logic        tw_en_i = 1'b0;
   logic [4:0]  tw_idx_i = '0;
   logic [63:0] tw_data_i = '0;
   logic [4:0]  tr_idx_i = '0;
   logic [63:0] tr_data_o;
   logic        match_o, undef_o, wr_en_o;
   logic [4:0]  wr_idx_o;
   logic [63:0] wr_data_o;

   int total = 0;
   int bad = 0;
   logic [63:0] mdl [32];

   always #2.5 clk = ~clk;

   simd_pairminmax dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
      .regs32_i(regs32_i), .tw_en_i(tw_en_i), .tw_idx_i(tw_idx_i),
      .tw_data_i(tw_data_i), .tr_idx_i(tr_idx_i), .tr_data_o(tr_data_o),
      .match_o(match_o), .undef_o(undef_o), .wr_en_o(wr_en_o),
      .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit u, input int sz, input bit mn,
                                      input int d, input int n, input int m);
      logic [31:0] w;
      w = 32'hF200_0A00;
      w[24] = u; w[21:20] = sz[1:0]; w[4] = mn;
      w[22] = d[4]; w[15:12] = d[3:0];
      w[7]  = n[4]; w[19:16] = n[3:0];
      w[5]  = m[4]; w[3:0]   = m[3:0];
      return w;
   endfunction

   function automatic logic [31:0] red_half(input logic [63:0] s, input int sz,
                                            input bit u, input bit mn);
      int ew;
      logic [31:0] r;
      longint a, b, mask;
      bit lt;
      ew = 8 << sz;
      mask = (ew == 32) ? 64'h0000_0000_FFFF_FFFF : ((64'd1 << ew) - 1);
      r = '0;
      for (int i = 0; i < 32 / ew; i++) begin
         a = longint'((s >> (2 * i * ew)) & mask);
         b = longint'((s >> ((2 * i + 1) * ew)) & mask);
         if (u) lt = (a < b);
         else begin
            if (((a >> (ew - 1)) & 1) == 1) a = a - (mask + 1);
            if (((b >> (ew - 1)) & 1) == 1) b = b - (mask + 1);
            lt = (a < b);
         end
         if (mn ? lt : !lt) r = r | 32'((a & mask) << (i * ew));
         else               r = r | 32'((b & mask) << (i * ew));
      end
      return r;
   endfunction

   task automatic twrite(input int idx, input logic [63:0] data);
      @(negedge clk);
      valid_i = 1'b0; tw_en_i = 1'b1; tw_idx_i = idx[4:0]; tw_data_i = data;
      mdl[idx] = data;
      @(negedge clk);
      tw_en_i = 1'b0;
   endtask

   task automatic rd_check(input int idx, input string req);
      @(negedge clk);
      valid_i = 1'b0; tw_en_i = 1'b0; tr_idx_i = idx[4:0];
      #1;
      chk(tr_data_o === mdl[idx], req, tr_data_o, mdl[idx]);
   endtask

   // Drives one instruction for one cycle and checks every output.
   task automatic run(input logic [31:0] w, input bit r32, input string req);
      bit hit, und;
      int sz, d, n, m;
      logic [63:0] exp;
      @(negedge clk);
      tw_en_i = 1'b0; valid_i = 1'b1; insn_i = w; regs32_i = r32;
      #1;
      hit = (w[31:25] == 7'b1111001) && !w[23] && (w[11:8] == 4'b1010) && !w[6];
      sz = int'(w[21:20]);
      d = int'({w[22], w[15:12]});
      n = int'({w[7], w[19:16]});
      m = int'({w[5], w[3:0]});
      und = hit && (sz == 3 || (!r32 && (d > 15 || n > 15 || m > 15)));
      chk(match_o === hit, {req, " match"}, 64'(match_o), 64'(hit));
      chk(undef_o === und, {req, " undef"}, 64'(undef_o), 64'(und));
      chk(wr_en_o === (hit && !und), {req, " wr_en"}, 64'(wr_en_o), 64'(hit && !und));
      if (hit && !und) begin
         exp = {red_half(mdl[m], sz, w[24], w[4]), red_half(mdl[n], sz, w[24], w[4])};
         chk(wr_idx_o === d[4:0], {req, " R4 idx"}, 64'(wr_idx_o), 64'(d));
         chk(wr_data_o === exp, {req, " data"}, wr_data_o, exp);
         mdl[d] = exp;
      end
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   initial begin
      #1000000;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      logic [31:0] w;
      bit r32;
      seed = $urandom(32'h5EED_1234);
      for (int i = 0; i < 32; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      rd_check(0, "R10 reset");
      rd_check(31, "R10 reset");
      rd_check(17, "R10 reset");

      // R10 test-port write, then boundary patterns
      twrite(1, 64'h7F80_FF01_8000_7FFF);
      twrite(2, 64'h8000_0000_7FFF_FFFF);
      twrite(3, 64'h0102_0304_F0E0_D0C0);
      rd_check(1, "R10 test write");
      rd_check(2, "R10 test write");
      for (int sz = 0; sz < 3; sz++)
         for (int u = 0; u < 2; u++)
            for (int mn = 0; mn < 2; mn++)
               run(mk(u[0], sz, mn[0], 10, 1, 2), 1'b1, "R2/R6/R7/R8 boundary");

      // R9 destination aliases a source
      run(mk(1'b0, 0, 1'b0, 3, 3, 1), 1'b1, "R9 d==n");
      rd_check(3, "R9 R11 d==n readback");
      twrite(4, 64'hFFEE_0011_8001_7FFE);
      run(mk(1'b1, 1, 1'b1, 4, 2, 4), 1'b1, "R9 d==m");
      rd_check(4, "R9 R11 d==m readback");

      // R3 size 3; destination must stay unchanged
      run(mk(1'b0, 3, 1'b0, 2, 1, 1), 1'b1, "R3 size3");
      rd_check(2, "R3 no write");
      // R5 upper bank
      twrite(20, 64'h0123_4567_89AB_CDEF);
      run(mk(1'b0, 1, 1'b0, 18, 20, 1), 1'b0, "R5 hi disabled");
      rd_check(18, "R5 no write");
      run(mk(1'b0, 1, 1'b0, 18, 20, 1), 1'b1, "R5 hi enabled");
      rd_check(18, "R5 R11 readback");
      // R1 non-matching word
      w = mk(1'b0, 0, 1'b0, 1, 2, 3); w[6] = 1'b1;
      run(w, 1'b1, "R1 bit6");
      rd_check(1, "R1 no write");
      w = mk(1'b0, 0, 1'b0, 1, 2, 3); w[23] = 1'b1;
      run(w, 1'b1, "R1 bit23");
      rd_check(1, "R1 no write");

      // Random fill and random instructions
      for (int i = 0; i < 32; i++)
         twrite(i, {$urandom, $urandom});
      for (int k = 0; k < 400; k++) begin
         int sz, d;
         sz = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
         d = int'($urandom % 32);
         w = mk(1'($urandom), sz, 1'($urandom), d,
                int'($urandom % 32), int'($urandom % 32));
         if ($urandom % 10 == 0) begin
            case ($urandom % 4)
               0: w[6] = 1'b1;
               1: w[23] = 1'b1;
               2: w[8] = 1'b1;
               default: w[25] = 1'b0;
            endcase
         end
         r32 = ($urandom % 6 != 0);
         run(w, r32, "R1/R2/R6/R8 random");
         if ($urandom % 4 == 0) rd_check(d, "R11 random readback");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule